// File: doc/BRIEF.md
# Squashable Instruction Buffer

This block sits between an instruction fetch stage and a dispatch stage. Fetch writes instructions in at the tail. Each instruction carries a sequence number, a program counter, an instruction word and a count of destination registers. Dispatch takes the oldest instruction from the head. Alongside the queue, the block keeps a credit counter of free physical registers. An accepted instruction takes its destination count out of the counter. External releases put credits back, and the counter never rises above the size of the register pool.

A misprediction recovery raises a squash with a boundary sequence number. The block then walks back from the tail, one entry per cycle, and discards every entry numbered above the boundary. The destination credits of each discarded entry go back to the counter. While the walk runs, the busy flag is high and the queue neither accepts nor hands out entries. The block also keeps running totals for the occupancy integrated over cycles, the cycles spent full, and the entries dispatched.

Top module: `sqz_ibuf`

## Requirements
- R1: After reset the buffer is empty, `free_regs` equals NUM_PREGS, `squash_busy` and `rename_blocked` are low, all three statistics are zero and `push_ready` is high.
- R2: Entries leave in the order they were accepted, with the seq, pc, word and destination count unchanged. `pop_valid` is low when the buffer is empty, and a `pop_req` on an empty buffer changes neither occupancy nor `dispatch_count`.
- R3: `push_ready` is low when occupancy equals DEPTH. A push offered then is dropped and occupancy stays at DEPTH.
- R4: An accepted push lowers `free_regs` by its `push_ndst` at the next clock edge.
- R5: A `squash_valid` seen while idle raises `squash_busy` at the next edge. Each later edge removes the tail entry if the buffer is non-empty and that entry's seq is above `squash_seq` (unsigned compare), or ends the walk otherwise. A squash that removes k entries keeps `squash_busy` high for k+1 cycles, and entries numbered at or below the boundary survive in order.
- R6: Each entry a squash removes adds its destination count back to `free_regs`.
- R7: A release adds `rel_count` to `free_regs`, and the result saturates at NUM_PREGS.
- R8: An accepted push that leaves `free_regs` at zero sets `rename_blocked`, which holds `push_ready` low. A release that leaves `free_regs` above zero clears it, and a release of zero leaves it set.
- R9: While `squash_busy` is high, `push_ready` and `pop_valid` are low, and a further `squash_valid` is ignored.
- R10: Every clock edge out of reset adds the current occupancy to `occ_accum`, and adds one to `full_cycles` when occupancy equals DEPTH.
- R11: Every accepted pop (`pop_req` with `pop_valid`) adds one to `dispatch_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Fetch offers an instruction |
| push_seq | input | 16 | Sequence number of the offered instruction |
| push_pc | input | 32 | Program counter |
| push_word | input | 32 | Instruction word |
| push_ndst | input | 2 | Destination register count |
| push_ready | output | 1 | Push is accepted this cycle |
| pop_req | input | 1 | Dispatch takes the head entry |
| pop_valid | output | 1 | Head entry is available |
| pop_seq | output | 16 | Head sequence number |
| pop_pc | output | 32 | Head program counter |
| pop_word | output | 32 | Head instruction word |
| pop_ndst | output | 2 | Head destination count |
| squash_valid | input | 1 | Start a squash |
| squash_seq | input | 16 | Boundary: entries above it are discarded |
| squash_busy | output | 1 | Squash walk in progress |
| rel_valid | input | 1 | Register release strobe |
| rel_count | input | $clog2(NUM_PREGS+1) | Registers released |
| free_regs | output | $clog2(NUM_PREGS+1) | Free physical register credits |
| rename_blocked | output | 1 | Fetch stalled for lack of registers |
| occupancy | output | $clog2(DEPTH)+1 | Entries held |
| occ_accum | output | STAT_W | Occupancy summed over cycles |
| full_cycles | output | STAT_W | Cycles spent full |
| dispatch_count | output | STAT_W | Entries dispatched |

## Verification
The properties assume that fetch never offers a push whose destination count exceeds the current `free_regs`. The block has no guard against this case, and the credit arithmetic would clamp at zero. The bench keeps within this rule by releasing a full pool before each fill and by using destination patterns whose sum stays under the pool size. Sequence numbers are assumed to rise without wrapping, and the bench uses small increasing values. Squash boundaries are swept across every position of a full buffer.

// File: rtl/sqz_ibuf_pkg.sv
package sqz_ibuf_pkg;
    localparam int SEQ_W  = 16;
    localparam int PC_W   = 32;
    localparam int WORD_W = 32;
    localparam int DCNT_W = 2;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   pc;
        logic [WORD_W-1:0] word;
        logic [DCNT_W-1:0] ndst;
    } ib_entry_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WALK = 1'b1
    } sq_state_e;

    // Unsigned age test: true when a was issued after b (no wrap assumed).
    function automatic logic is_younger(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
        return a > b;
    endfunction
endpackage

// File: rtl/sqz_ibuf_store.sv
module sqz_ibuf_store
    import sqz_ibuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  ib_entry_t         wr_entry,
    input  logic              rd_en,
    input  logic              drop_en,
    output ib_entry_t         head_entry,
    output logic [SEQ_W-1:0]  tail_seq,
    output logic [DCNT_W-1:0] tail_ndst,
    output logic [CW-1:0]     count
);
    ib_entry_t       mem [DEPTH];
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic [AW-1:0]   last_ptr;

    assign last_ptr   = wr_ptr - 1'b1;
    assign head_entry = mem[rd_ptr];
    assign tail_seq   = mem[last_ptr].seq;
    assign tail_ndst  = mem[last_ptr].ndst;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            else if (drop_en) wr_ptr <= last_ptr;
            count <= count + CW'(wr_en) - CW'(rd_en) - CW'(drop_en);
        end
    end
endmodule

// File: rtl/sqz_ibuf_credit.sv
module sqz_ibuf_credit
    import sqz_ibuf_pkg::*;
#(
    parameter int NUM_PREGS = 16,
    localparam int FW = $clog2(NUM_PREGS + 1),
    localparam int SW = FW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_en,
    input  logic [DCNT_W-1:0] take_n,
    input  logic              give_en,
    input  logic [DCNT_W-1:0] give_n,
    input  logic              rel_en,
    input  logic [FW-1:0]     rel_n,
    output logic [FW-1:0]     free,
    output logic              blocked
);
    logic [SW-1:0] base, nxt;

    always_comb begin
        base = SW'(free);
        if (give_en) base = base + SW'(give_n);
        if (rel_en)  base = base + SW'(rel_n);
        nxt = base;
        if (take_en) nxt = (base >= SW'(take_n)) ? base - SW'(take_n) : '0;
        if (nxt > SW'(NUM_PREGS)) nxt = SW'(NUM_PREGS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free    <= FW'(NUM_PREGS);
            blocked <= 1'b0;
        end else begin
            free <= nxt[FW-1:0];
            if (take_en && nxt == '0)      blocked <= 1'b1;
            else if (rel_en && nxt != '0)  blocked <= 1'b0;
        end
    end
endmodule

// File: rtl/sqz_ibuf_stats.sv
module sqz_ibuf_stats #(
    parameter int DEPTH  = 8,
    parameter int STAT_W = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     count,
    input  logic              pop_fire,
    output logic [STAT_W-1:0] occ_accum,
    output logic [STAT_W-1:0] full_cycles,
    output logic [STAT_W-1:0] dispatch_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            occ_accum      <= '0;
            full_cycles    <= '0;
            dispatch_count <= '0;
        end else begin
            occ_accum <= occ_accum + STAT_W'(count);
            if (count == CW'(DEPTH)) full_cycles <= full_cycles + 1'b1;
            if (pop_fire) dispatch_count <= dispatch_count + 1'b1;
        end
    end
endmodule

// File: rtl/sqz_ibuf.sv
module sqz_ibuf
    import sqz_ibuf_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int NUM_PREGS = 16,
    parameter int STAT_W    = 32,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int FW = $clog2(NUM_PREGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [WORD_W-1:0] push_word,
    input  logic [DCNT_W-1:0] push_ndst,
    output logic              push_ready,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [SEQ_W-1:0]  pop_seq,
    output logic [PC_W-1:0]   pop_pc,
    output logic [WORD_W-1:0] pop_word,
    output logic [DCNT_W-1:0] pop_ndst,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              squash_busy,
    input  logic              rel_valid,
    input  logic [FW-1:0]     rel_count,
    output logic [FW-1:0]     free_regs,
    output logic              rename_blocked,
    output logic [CW-1:0]     occupancy,
    output logic [STAT_W-1:0] occ_accum,
    output logic [STAT_W-1:0] full_cycles,
    output logic [STAT_W-1:0] dispatch_count
);
    sq_state_e         sq_state;
    logic [SEQ_W-1:0]  sq_bound;
    ib_entry_t         wr_entry, head_entry;
    logic [SEQ_W-1:0]  tail_seq;
    logic [DCNT_W-1:0] tail_ndst;
    logic              push_fire, pop_fire, drop_en;

    assign squash_busy = (sq_state == SQ_WALK);
    assign push_ready  = (occupancy != CW'(DEPTH)) && !squash_busy && !rename_blocked;
    assign pop_valid   = (occupancy != '0) && !squash_busy;
    assign push_fire   = push_valid && push_ready;
    assign pop_fire    = pop_req && pop_valid;
    assign drop_en     = squash_busy && (occupancy != '0) && is_younger(tail_seq, sq_bound);

    assign wr_entry = '{seq: push_seq, pc: push_pc, word: push_word, ndst: push_ndst};
    assign pop_seq  = head_entry.seq;
    assign pop_pc   = head_entry.pc;
    assign pop_word = head_entry.word;
    assign pop_ndst = head_entry.ndst;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_state <= SQ_IDLE;
            sq_bound <= '0;
        end else begin
            unique case (sq_state)
                SQ_IDLE: if (squash_valid) begin
                    sq_state <= SQ_WALK;
                    sq_bound <= squash_seq;
                end
                SQ_WALK: if (!drop_en) sq_state <= SQ_IDLE;
                default: sq_state <= SQ_IDLE;
            endcase
        end
    end

    sqz_ibuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(push_fire), .wr_entry(wr_entry),
        .rd_en(pop_fire), .drop_en(drop_en),
        .head_entry(head_entry), .tail_seq(tail_seq), .tail_ndst(tail_ndst),
        .count(occupancy)
    );

    sqz_ibuf_credit #(.NUM_PREGS(NUM_PREGS)) u_credit (
        .clk(clk), .rst(rst),
        .take_en(push_fire), .take_n(push_ndst),
        .give_en(drop_en), .give_n(tail_ndst),
        .rel_en(rel_valid), .rel_n(rel_count),
        .free(free_regs), .blocked(rename_blocked)
    );

    sqz_ibuf_stats #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_stats (
        .clk(clk), .rst(rst),
        .count(occupancy), .pop_fire(pop_fire),
        .occ_accum(occ_accum), .full_cycles(full_cycles),
        .dispatch_count(dispatch_count)
    );
endmodule

// File: rtl/sqz_ibuf_chk.sv
module sqz_ibuf_chk #(
    parameter int DEPTH     = 8,
    parameter int NUM_PREGS = 16,
    parameter int STAT_W    = 32,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int FW = $clog2(NUM_PREGS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_ready,
    input logic              pop_req,
    input logic              pop_valid,
    input logic              squash_busy,
    input logic [FW-1:0]     free_regs,
    input logic              rename_blocked,
    input logic [CW-1:0]     occupancy,
    input logic [STAT_W-1:0] full_cycles,
    input logic [STAT_W-1:0] dispatch_count
);
    p_empty_no_pop_r2: assert property (@(posedge clk) disable iff (rst)
        occupancy == '0 |-> !pop_valid);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occupancy == CW'(DEPTH) |-> !push_ready);

    p_bounded_occ_r3: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CW'(DEPTH));

    p_squash_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
        squash_busy |=> occupancy <= $past(occupancy));

    p_free_bound_r7: assert property (@(posedge clk) disable iff (rst)
        free_regs <= FW'(NUM_PREGS));

    p_blocked_stall_r8: assert property (@(posedge clk) disable iff (rst)
        rename_blocked |-> !push_ready);

    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        squash_busy |-> (!push_ready && !pop_valid));

    p_full_count_r10: assert property (@(posedge clk) disable iff (rst)
        occupancy == CW'(DEPTH) |=> full_cycles == $past(full_cycles) + 1'b1);

    p_dispatch_r11: assert property (@(posedge clk) disable iff (rst)
        (pop_req && pop_valid) |=> dispatch_count == $past(dispatch_count) + 1'b1);
endmodule

bind sqz_ibuf sqz_ibuf_chk #(.DEPTH(DEPTH), .NUM_PREGS(NUM_PREGS), .STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst(rst), .push_ready(push_ready), .pop_req(pop_req),
    .pop_valid(pop_valid), .squash_busy(squash_busy), .free_regs(free_regs),
    .rename_blocked(rename_blocked), .occupancy(occupancy),
    .full_cycles(full_cycles), .dispatch_count(dispatch_count)
);

// File: tb/sqz_ibuf_tb.sv
module sqz_ibuf_tb;
    localparam int DEPTH = 8;
    localparam int NPR   = 16;

    logic clk = 0;
    logic rst = 1;
    logic push_valid = 0, pop_req = 0, squash_valid = 0, rel_valid = 0;
    logic [15:0] push_seq = '0, squash_seq = '0;
    logic [31:0] push_pc = '0, push_word = '0;
    logic [1:0]  push_ndst = '0;
    logic [4:0]  rel_count = '0;
    logic push_ready, pop_valid, squash_busy, rename_blocked;
    logic [15:0] pop_seq;
    logic [31:0] pop_pc, pop_word;
    logic [1:0]  pop_ndst;
    logic [4:0]  free_regs;
    logic [3:0]  occupancy;
    logic [31:0] occ_accum, full_cycles, dispatch_count;

    always #5 clk = ~clk;

    sqz_ibuf #(.DEPTH(DEPTH), .NUM_PREGS(NPR), .STAT_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_seq(push_seq), .push_pc(push_pc),
        .push_word(push_word), .push_ndst(push_ndst), .push_ready(push_ready),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_seq(pop_seq),
        .pop_pc(pop_pc), .pop_word(pop_word), .pop_ndst(pop_ndst),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .squash_busy(squash_busy),
        .rel_valid(rel_valid), .rel_count(rel_count), .free_regs(free_regs),
        .rename_blocked(rename_blocked), .occupancy(occupancy),
        .occ_accum(occ_accum), .full_cycles(full_cycles), .dispatch_count(dispatch_count)
    );

    int n_chk = 0, n_fail = 0;
    int m_seq [DEPTH];
    int m_n   [DEPTH];
    int m_cnt = 0, m_free = NPR, m_blk = 0, m_fullc = 0, m_disp = 0;
    longint m_acc = 0;

    function automatic logic [31:0] word_of(int s);
        return 32'(s) ^ 32'hC0DE_0000;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        m_acc += m_cnt;
        if (m_cnt == DEPTH) m_fullc++;
        @(negedge clk);
    endtask

    task automatic push(int s, int n);
        bit exp_rdy;
        exp_rdy = (m_cnt < DEPTH) && (m_blk == 0);
        chk("R3/R8 push_ready", push_ready, exp_rdy);
        push_valid = 1; push_seq = 16'(s); push_ndst = 2'(n);
        push_pc = 32'(s) << 2; push_word = word_of(s);
        step();
        push_valid = 0;
        if (exp_rdy) begin
            m_seq[m_cnt] = s; m_n[m_cnt] = n; m_cnt++;
            m_free -= n;
            if (m_free == 0) m_blk = 1;
        end
        chk("R4 free after push", free_regs, m_free);
        chk("R3 occupancy after push", occupancy, m_cnt);
    endtask

    task automatic pop_one();
        chk("R2 pop_valid", pop_valid, m_cnt > 0);
        if (m_cnt > 0) begin
            chk("R2 head seq", pop_seq, m_seq[0]);
            chk("R2 head pc", pop_pc, 32'(m_seq[0]) << 2);
            chk("R2 head word", pop_word, word_of(m_seq[0]));
            chk("R2 head ndst", pop_ndst, m_n[0]);
        end
        pop_req = 1;
        step();
        pop_req = 0;
        if (m_cnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_seq[i] = m_seq[i+1]; m_n[i] = m_n[i+1];
            end
            m_cnt--; m_disp++;
        end
        chk("R11 dispatch_count", dispatch_count, m_disp);
        chk("R2 occupancy after pop", occupancy, m_cnt);
    endtask

    task automatic release_regs(int n);
        rel_valid = 1; rel_count = 5'(n);
        step();
        rel_valid = 0;
        m_free = (m_free + n > NPR) ? NPR : m_free + n;
        if (m_free > 0) m_blk = 0;
        chk("R7 free after release", free_regs, m_free);
        chk("R8 rename_blocked after release", rename_blocked, m_blk);
    endtask

    task automatic squash(int s);
        int k, cyc;
        bit rem;
        k = 0;
        while (k < m_cnt && m_seq[m_cnt-1-k] > s) k++;
        squash_valid = 1; squash_seq = 16'(s);
        step();
        squash_valid = 0;
        chk("R5 busy after request", squash_busy, 1);
        cyc = 0;
        while (squash_busy && cyc < 64) begin
            chk("R9 push_ready while busy", push_ready, 0);
            chk("R9 pop_valid while busy", pop_valid, 0);
            if (cyc == 0) begin
                squash_valid = 1; squash_seq = 16'h0;   // R9: must be ignored
            end
            rem = (m_cnt > 0) && (m_seq[m_cnt-1] > s);
            step();
            squash_valid = 0;
            if (rem) begin
                m_cnt--;
                m_free = (m_free + m_n[m_cnt] > NPR) ? NPR : m_free + m_n[m_cnt];
            end
            cyc++;
        end
        chk("R5 busy duration", cyc, k + 1);
        chk("R5 occupancy after squash", occupancy, m_cnt);
        chk("R6 free after squash", free_regs, m_free);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 occupancy", occupancy, 0);
        chk("R1 free_regs", free_regs, NPR);
        chk("R1 squash_busy", squash_busy, 0);
        chk("R1 rename_blocked", rename_blocked, 0);
        chk("R1 push_ready", push_ready, 1);
        chk("R1 stats", occ_accum + full_cycles + dispatch_count, 0);

        // R2: pop on empty is ignored
        pop_one();

        // R3/R4: fill to capacity with a mixed destination pattern
        for (int i = 0; i < DEPTH; i++) push(10 + i, i % 3);
        push(99, 1);                       // R3: dropped while full
        step();                            // R10: one more full cycle

        // R2/R11: head order
        for (int i = 0; i < 3; i++) pop_one();

        // R5/R6: squash the youngest three
        squash(14);
        squash(40);                        // R5: nothing younger
        pop_one(); pop_one();
        squash(5);                         // R5: empty buffer

        // simultaneous push and pop
        push(50, 1);
        push_valid = 1; push_seq = 16'd51; push_ndst = 2'd2;
        push_pc = 32'd51 << 2; push_word = word_of(51);
        pop_req = 1;
        step();
        push_valid = 0; pop_req = 0;
        m_seq[0] = 51; m_n[0] = 2; m_free -= 2; m_disp++;
        chk("R2 occupancy push+pop", occupancy, m_cnt);
        chk("R11 dispatch push+pop", dispatch_count, m_disp);
        pop_one();

        // R5: sweep squash boundary across a full buffer
        for (int b = 0; b <= DEPTH; b++) begin
            release_regs(NPR);             // R7: saturates
            for (int i = 0; i < DEPTH; i++) push(100 + i, (i + b) % 4 == 3 ? 1 : (i + b) % 4);
            squash(99 + b);
            while (m_cnt > 0) pop_one();
        end

        // R8: drain the pool to zero
        release_regs(NPR);
        for (int i = 0; i < 5; i++) push(200 + i, 3);
        push(205, 1);
        chk("R8 blocked at zero", rename_blocked, 1);
        chk("R8 push_ready low", push_ready, 0);
        push(206, 0);                      // R8: refused while blocked
        release_regs(0);                   // stays blocked
        release_regs(2);                   // clears
        chk("R8 push_ready back", push_ready, 1);
        while (m_cnt > 0) pop_one();

        // R10: statistics totals
        step();
        chk("R10 occ_accum", occ_accum, m_acc);
        chk("R10 full_cycles", full_cycles, m_fullc);
        chk("R11 dispatch total", dispatch_count, m_disp);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule